// File: doc/BRIEF.md
# Shifted Block Window Unit

This unit keeps a reference region of 8-bit pixels in a two-dimensional shift register of 8 rows by 16 columns. It feeds an arithmetic array that does convolution or block matching. In every scan cycle it emits two windows at once on two flat buses. Window B is the same shape as window A, moved one column to the right. Over four scan cycles the base column steps through 0, 2, 4 and 6, so the pair of windows sweeps the stored region horizontally. After that the unit waits for a new image row. The new row enters at the bottom, every stored row moves up by one, and the next sweep starts. This gives horizontal reuse within a sweep and vertical reuse between sweeps.

There are three window shapes. The square mode cuts out k×k blocks. The column mode reads one register column of length k per window, for vertical filters. The tap mode reads a one-dimensional run of k pixels from the newest row, for horizontal filters. The size k is 2, 4 or 8 and is set by a two-bit select. Rows arrive through a valid/ready handshake. The sweep schedule stalls for as long as no new row is offered.

Top module: `shift_block_window`

## Requirements
- R1: While reset is active and in the first cycle after it, `row_ready` is 1, `out_valid` is 0 and `row_shift_done` is 0.
- R2: After reset, `out_valid` stays 0 until 8 rows have been accepted. The cycle right after the 8th accepted row is the first scan cycle.
- R3: A sweep is exactly four consecutive cycles with `out_valid`=1, and `out_offset` reads 0, 2, 4 and 6 in that order. `row_ready` is 0 in every scan cycle.
- R4: After the offset-6 cycle, `out_valid` is 0 and `row_ready` is 1. This lasts for any number of cycles until a row is accepted.
- R5: An accepted row (`row_valid` and `row_ready` both 1 at a clock edge) becomes stored row 7, the bottom row. Every stored row r takes the old row r+1, and the old top row 0 is dropped. Column c of the row is `row_data[c*8 +: 8]`.
- R6: `row_shift_done` is 1 for exactly one cycle. That cycle is the first scan cycle after a row accepted while waiting. The pulse never appears after the rows accepted during the initial fill.
- R7: `mode_sel` 0 or 3 selects square windows. Window A is rows 0..k-1 × columns off..off+k-1, and window B uses columns off+1..off+k. The size code in `size_sel` decodes as 0→k=2, 1→k=4, 2 or 3→k=8.
- R8: `mode_sel` 1 selects column windows. Window A is stored column off, rows 0..k-1, placed in bus column 0. Window B is column off+1.
- R9: `mode_sel` 2 selects tap windows taken from stored row 7. Window A is columns off..off+k-1, placed in bus row 0. Window B starts at off+1.
- R10: In both buses, window pixel (r,c) sits at bits `[(r*8+c)*8 +: 8]`. Every position outside the selected window reads 0.
- R11: A row offered while `row_ready` is 0 is ignored. The stored contents and the sweep progress are both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | A new row is offered on row_data |
| row_ready | output | 1 | The unit takes a row at this edge |
| row_data | input | 128 | 16 pixels; column c at bits c*8 +: 8 |
| mode_sel | input | 2 | Window shape: 0/3 square, 1 column, 2 taps |
| size_sel | input | 2 | Window size code: 0→2, 1→4, 2/3→8 |
| out_valid | output | 1 | The window buses hold a sweep position |
| out_offset | output | 4 | Base column of window A |
| blk_a | output | 512 | Window at the base column, 8×8 pixel grid |
| blk_b | output | 512 | Window one column to the right |
| row_shift_done | output | 1 | One-cycle mark of the first cycle after a vertical shift |

## Verification
Each row is filled with pixels that are a function of both the row's arrival number and the column. A wrong row, a wrong column or a missing shift therefore changes at least one compared pixel. A table walks every shape and size code, including the alias codes 3, across successive sweeps. The full 64-pixel grid of both buses is compared, so window B differing from window A by exactly one column is checked, and so are the zero positions around each window. Rows offered in scan cycles, and a stall of several cycles before a row arrives, separate a correct handshake from one that shifts early or lets the offset run on.

// File: rtl/win_pkg.sv
package win_pkg;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_SCAN = 2'd1,
        ST_WAIT = 2'd2
    } win_state_t;

    typedef enum logic [1:0] {
        SHAPE_SQUARE     = 2'd0,
        SHAPE_COLUMN     = 2'd1,
        SHAPE_TAPS       = 2'd2,
        SHAPE_SQUARE_ALT = 2'd3
    } win_shape_t;

    function automatic int size_decode(input logic [1:0] code, input int bmax);
        int k;
        k = 2 << code;
        if (k > bmax) k = bmax;
        return k;
    endfunction

endpackage

// File: rtl/win_regfile.sv
module win_regfile #(
    parameter int PIX_W = 8,
    parameter int ROWS  = 8,
    parameter int COLS  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [COLS*PIX_W-1:0]       row_in,
    output logic [ROWS*COLS*PIX_W-1:0]  grid
);
    localparam int RW = COLS * PIX_W;

    logic [RW-1:0] rows_q [ROWS];

    // Each row takes its lower neighbour on a shift; the bottom row takes the input.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        if (r == ROWS - 1) begin : g_bottom
            always_ff @(posedge clk) begin
                if (!rst_n)        rows_q[r] <= '0;
                else if (shift_en) rows_q[r] <= row_in;
            end
        end else begin : g_upper
            always_ff @(posedge clk) begin
                if (!rst_n)        rows_q[r] <= '0;
                else if (shift_en) rows_q[r] <= rows_q[r+1];
            end
        end
        assign grid[r*RW +: RW] = rows_q[r];
    end

    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> grid[(ROWS-1)*RW +: RW] == $past(row_in));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(grid));

endmodule

// File: rtl/win_ctrl.sv
module win_ctrl
    import win_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int PAIRS = 4,
    parameter int STEP  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     row_valid,
    output logic                     row_ready,
    output logic                     shift_en,
    output logic                     out_valid,
    output logic [$clog2(COLS)-1:0]  out_offset,
    output logic                     row_shift_done
);
    localparam int OFF_W = $clog2(COLS);
    localparam int PI_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int FC_W  = $clog2(ROWS + 1);
    localparam logic [PI_W-1:0]  LAST_PAIR = PI_W'(PAIRS - 1);
    localparam logic [FC_W-1:0]  LAST_FILL = FC_W'(ROWS - 1);
    localparam logic [OFF_W-1:0] STEP_V    = OFF_W'(STEP);

    win_state_t       state_q, state_d;
    logic [FC_W-1:0]  fill_cnt;
    logic [PI_W-1:0]  pair_idx;
    logic             done_q;
    logic             accept;

    assign accept = row_valid && row_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // Transitions: FILL->SCAN on last fill row, SCAN->WAIT after last pair,
    // WAIT->SCAN when a row is accepted.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (accept && fill_cnt == LAST_FILL) state_d = ST_SCAN;
            ST_SCAN: if (pair_idx == LAST_PAIR)           state_d = ST_WAIT;
            ST_WAIT: if (accept)                          state_d = ST_SCAN;
            default:                                      state_d = ST_FILL;
        endcase
    end

    // Counters and the post-shift mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            pair_idx <= '0;
            done_q   <= 1'b0;
        end else begin
            if (state_q == ST_FILL && accept) fill_cnt <= fill_cnt + 1'b1;
            if (state_q == ST_SCAN) begin
                if (pair_idx == LAST_PAIR) pair_idx <= '0;
                else                       pair_idx <= pair_idx + 1'b1;
            end
            done_q <= (state_q == ST_WAIT) && accept;
        end
    end

    // Outputs
    always_comb begin
        row_ready      = (state_q != ST_SCAN);
        out_valid      = (state_q == ST_SCAN);
        shift_en       = accept;
        out_offset     = OFF_W'(pair_idx) * STEP_V;
        row_shift_done = done_q;
    end

    p_scan_no_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !row_ready);

    p_offset_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pair_idx != LAST_PAIR) |=>
            (out_valid && out_offset == $past(out_offset) + STEP_V));

    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !row_valid) |=> (!out_valid && row_ready));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_shift_done |=> !row_shift_done);

    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_shift_done |-> ($past(shift_en) && out_valid && out_offset == '0));

endmodule

// File: rtl/win_extract.sv
module win_extract
    import win_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int BMAX  = 8,
    parameter int LANE  = 0
) (
    input  logic [ROWS*COLS*PIX_W-1:0]  grid,
    input  logic [1:0]                  mode_sel,
    input  logic [1:0]                  size_sel,
    input  logic [$clog2(COLS)-1:0]     offset,
    output logic [BMAX*BMAX*PIX_W-1:0]  blk
);
    win_shape_t shape;
    int         kk;
    int         base;

    assign shape = win_shape_t'(mode_sel);

    always_comb begin
        kk   = size_decode(size_sel, BMAX);
        base = int'(offset) + LANE;
        blk  = '0;
        for (int r = 0; r < BMAX; r++) begin
            for (int c = 0; c < BMAX; c++) begin
                logic use_pix;
                int   sr;
                int   sc;
                use_pix = 1'b0;
                sr      = 0;
                sc      = 0;
                unique case (shape)
                    SHAPE_COLUMN: begin
                        use_pix = (c == 0) && (r < kk);
                        sr      = r;
                        sc      = base;
                    end
                    SHAPE_TAPS: begin
                        use_pix = (r == 0) && (c < kk);
                        sr      = ROWS - 1;
                        sc      = base + c;
                    end
                    SHAPE_SQUARE, SHAPE_SQUARE_ALT: begin
                        use_pix = (r < kk) && (c < kk);
                        sr      = r;
                        sc      = base + c;
                    end
                    default: use_pix = 1'b0;
                endcase
                if (use_pix && sc < COLS && sr < ROWS)
                    blk[(r*BMAX + c)*PIX_W +: PIX_W] = grid[(sr*COLS + sc)*PIX_W +: PIX_W];
            end
        end
    end

endmodule

// File: rtl/shift_block_window.sv
module shift_block_window
    import win_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int BMAX  = 8,
    parameter int PAIRS = 4,
    parameter int STEP  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        row_valid,
    output logic                        row_ready,
    input  logic [COLS*PIX_W-1:0]       row_data,
    input  logic [1:0]                  mode_sel,
    input  logic [1:0]                  size_sel,
    output logic                        out_valid,
    output logic [$clog2(COLS)-1:0]     out_offset,
    output logic [BMAX*BMAX*PIX_W-1:0]  blk_a,
    output logic [BMAX*BMAX*PIX_W-1:0]  blk_b,
    output logic                        row_shift_done
);
    localparam int GRID_W = ROWS * COLS * PIX_W;
    localparam int BLK_W  = BMAX * BMAX * PIX_W;
    localparam int LANES  = 2;

    logic              shift_en;
    logic [GRID_W-1:0] grid;
    logic [BLK_W-1:0]  lane_bus [LANES];

    win_ctrl #(
        .ROWS (ROWS),
        .COLS (COLS),
        .PAIRS(PAIRS),
        .STEP (STEP)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .row_valid     (row_valid),
        .row_ready     (row_ready),
        .shift_en      (shift_en),
        .out_valid     (out_valid),
        .out_offset    (out_offset),
        .row_shift_done(row_shift_done)
    );

    win_regfile #(
        .PIX_W(PIX_W),
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .row_in  (row_data),
        .grid    (grid)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        win_extract #(
            .PIX_W(PIX_W),
            .ROWS (ROWS),
            .COLS (COLS),
            .BMAX (BMAX),
            .LANE (l)
        ) u_ext (
            .grid    (grid),
            .mode_sel(mode_sel),
            .size_sel(size_sel),
            .offset  (out_offset),
            .blk     (lane_bus[l])
        );
    end

    assign blk_a = lane_bus[0];
    assign blk_b = lane_bus[1];

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (row_ready && !out_valid && !row_shift_done));

endmodule

// File: tb/sim_shift_block_window.sv
module sim_shift_block_window;
    localparam int PW   = 8;
    localparam int ROWS = 8;
    localparam int COLS = 16;
    localparam int BM   = 8;

    // {mode[8:7], size[6:5], offer_row_in_scan[4], expected_k[3:0]}
    localparam logic [8:0] VEC [16] = '{
        {2'd0, 2'd0, 1'b0, 4'd2}, {2'd0, 2'd1, 1'b0, 4'd4},
        {2'd0, 2'd2, 1'b0, 4'd8}, {2'd0, 2'd3, 1'b0, 4'd8},
        {2'd1, 2'd0, 1'b0, 4'd2}, {2'd1, 2'd1, 1'b1, 4'd4},
        {2'd1, 2'd2, 1'b0, 4'd8}, {2'd3, 2'd1, 1'b0, 4'd4},
        {2'd2, 2'd0, 1'b0, 4'd2}, {2'd2, 2'd1, 1'b0, 4'd4},
        {2'd2, 2'd2, 1'b1, 4'd8}, {2'd2, 2'd3, 1'b0, 4'd8},
        {2'd0, 2'd2, 1'b0, 4'd8}, {2'd1, 2'd3, 1'b0, 4'd8},
        {2'd2, 2'd1, 1'b0, 4'd4}, {2'd0, 2'd0, 1'b1, 4'd2}
    };

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  row_valid;
    logic                  row_ready;
    logic [COLS*PW-1:0]    row_data;
    logic [1:0]            mode_sel;
    logic [1:0]            size_sel;
    logic                  out_valid;
    logic [3:0]            out_offset;
    logic [BM*BM*PW-1:0]   blk_a;
    logic [BM*BM*PW-1:0]   blk_b;
    logic                  row_shift_done;

    int  total = 0;
    int  fails = 0;
    int  top_id = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    shift_block_window u0 (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_ready(row_ready),
        .row_data(row_data), .mode_sel(mode_sel), .size_sel(size_sel),
        .out_valid(out_valid), .out_offset(out_offset), .blk_a(blk_a),
        .blk_b(blk_b), .row_shift_done(row_shift_done)
    );

    function automatic logic [7:0] pix_of(input int id, input int col);
        return 8'((id * 17 + col * 3 + 1) & 255);
    endfunction

    function automatic logic [COLS*PW-1:0] mk_row(input int id);
        logic [COLS*PW-1:0] v;
        for (int c = 0; c < COLS; c++) v[c*PW +: PW] = pix_of(id, c);
        return v;
    endfunction

    function automatic logic [7:0] model(input int lane, input int r, input int c,
                                         input int mode, input int k, input int off);
        int col;
        col = off + lane + c;
        if (mode == 1) return (c == 0 && r < k) ? pix_of(top_id + r, off + lane) : 8'd0;
        if (mode == 2) return (r == 0 && c < k) ? pix_of(top_id + ROWS - 1, col) : 8'd0;
        return (r < k && c < k) ? pix_of(top_id + r, col) : 8'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_lane(input int lane, input int mode, input int k, input int off,
                            input string req);
        logic [BM*BM*PW-1:0] bus;
        int bad_r, bad_c;
        logic [7:0] got, want;
        bus = (lane == 0) ? blk_a : blk_b;
        bad_r = -1; bad_c = -1; got = 0; want = 0;
        for (int r = 0; r < BM; r++)
            for (int c = 0; c < BM; c++)
                if (bad_r < 0 && bus[(r*BM + c)*PW +: PW] !== model(lane, r, c, mode, k, off)) begin
                    bad_r = r; bad_c = c;
                    got  = bus[(r*BM + c)*PW +: PW];
                    want = model(lane, r, c, mode, k, off);
                end
        total++;
        if (bad_r >= 0) begin
            fails++;
            $display("FAIL %s lane %0d pixel (%0d,%0d) actual=%0d expected=%0d",
                     req, lane, bad_r, bad_c, got, want);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; row_valid = 1'b0; row_data = '0; mode_sel = 2'd0; size_sel = 2'd0;
        repeat (3) @(negedge clk);
        #1;
        chk(row_ready == 1'b1, "R1 row_ready in reset", row_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(row_shift_done == 1'b0, "R1 row_shift_done in reset", row_shift_done, 0);
        rst_n = 1'b1;
        tick();
        #1;
        chk(row_ready && !out_valid && !row_shift_done, "R1 idle after reset",
            {row_ready, out_valid, row_shift_done}, 3'b100);

        // Initial fill: rows 0..7
        for (int id = 0; id < ROWS; id++) begin
            chk(out_valid == 1'b0, "R2 no output during fill", out_valid, 0);
            row_valid = 1'b1;
            row_data  = mk_row(id);
            tick();
            row_valid = 1'b0;
            #1;
        end
        top_id = 0;

        // Table walk: four sweeps of four positions each
        for (int s = 0; s < 4; s++) begin
            bit prev_junk;
            prev_junk = 1'b0;
            for (int j = 0; j < 4; j++) begin
                logic [8:0] v;
                int md, k;
                v  = VEC[s*4 + j];
                md = int'(v[8:7]);
                k  = int'(v[3:0]);
                mode_sel = v[8:7];
                size_sel = v[6:5];
                if (v[4]) begin
                    row_valid = 1'b1;
                    row_data  = '1;
                end
                #1;
                chk(out_valid == 1'b1, "R3 out_valid in sweep", out_valid, 1);
                chk(int'(out_offset) == 2*j, "R3 sweep offset", out_offset, 2*j);
                chk(row_ready == 1'b0, "R3 row_ready low in sweep", row_ready, 0);
                chk(row_shift_done == (j == 0 && s > 0), "R6 shift mark",
                    row_shift_done, (j == 0 && s > 0));
                if (md == 1) begin
                    chk_lane(0, md, k, 2*j, "R8 R10 column window");
                    chk_lane(1, md, k, 2*j, "R8 R10 column window");
                end else if (md == 2) begin
                    chk_lane(0, md, k, 2*j, "R9 R10 tap window");
                    chk_lane(1, md, k, 2*j, "R9 R10 tap window");
                end else begin
                    chk_lane(0, md, k, 2*j, "R7 R10 square window");
                    chk_lane(1, md, k, 2*j, "R7 R10 square window");
                end
                if (j == 0 && s > 0) chk_lane(0, md, k, 0, "R5 contents after shift");
                if (prev_junk) chk_lane(1, md, k, 2*j, "R11 row offered in sweep ignored");
                prev_junk = v[4];
                tick();
                row_valid = 1'b0;
            end
            #1;
            chk(out_valid == 1'b0 && row_ready == 1'b1, "R4 waiting for row",
                {out_valid, row_ready}, 2'b01);
            if (prev_junk) begin
                mode_sel = 2'd0; size_sel = 2'd2;
            end
            repeat (3 + s) tick();
            #1;
            chk(out_valid == 1'b0 && row_ready == 1'b1, "R4 stall holds",
                {out_valid, row_ready}, 2'b01);
            chk(row_shift_done == 1'b0, "R6 no mark while waiting", row_shift_done, 0);
            if (s < 3) begin
                row_valid = 1'b1;
                row_data  = mk_row(ROWS + s);
                tick();
                row_valid = 1'b0;
                top_id++;
            end
        end

        // Next sweep after one more row, checking the single-cycle mark
        row_valid = 1'b1;
        row_data  = mk_row(ROWS + 3);
        tick();
        row_valid = 1'b0;
        top_id++;
        mode_sel = 2'd2; size_sel = 2'd2;
        #1;
        chk(row_shift_done == 1'b1, "R6 mark present", row_shift_done, 1);
        chk_lane(0, 2, 8, 0, "R5 newest row at bottom");
        tick();
        #1;
        chk(row_shift_done == 1'b0, "R6 mark lasts one cycle", row_shift_done, 0);
        chk(int'(out_offset) == 2, "R3 offset after mark", out_offset, 2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule